// File: doc/BRIEF.md
# Host-to-Coprocessor Byte Mailbox

This block passes bytes between a host processor and a coprocessor that sit on separate port-mapped buses clocked by one shared clock. The host posts a command byte and raises a pending-command flag. It can also exchange a data byte in either direction. Each data transfer raises or lowers a data-ready flag. Both sides read one status byte that shows the two flags at fixed bit positions. The coprocessor lowers the command flag by touching a dedicated clear port, with either a read or a write.

A host control port drives three side channels to the coprocessor. One bit starts a stretched reset, one bit fires a single-cycle non-maskable interrupt pulse, and one bit toggles an indicator LED. Every bus access is a single-cycle strobe. Read data is combinational and reflects the state before the strobe's clock edge. All flag and register updates take effect at that edge.

Host addresses: 0 is command (write) and status (read), 1 is data (read/write), 2 is control (write). Coprocessor addresses: 0 is command read, 1 is data read, 2 is data write, 3 is status read, 4 is clear-command (read or write).

Top module: `host_mailbox`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), both flags are 0, the command register and both data registers are 0x00, cop_nmi and cop_reset are 0, and led_on is 1.
- R2: The status byte has the command flag in bit 0, the data flag in bit 7, and zeros in bits 6..1. The host reads it at host address 0 and the coprocessor at address 3. Reading status or the command port changes no flag.
- R3: A host write to host address 0 stores the byte and sets the command flag at that edge. A coprocessor read of address 0 returns the stored byte.
- R4: A coprocessor read or a coprocessor write of address 4 clears the command flag at that edge.
- R5: A coprocessor write to address 2 stores the byte for the host and sets the data flag. A host read of address 1 returns that byte and clears the data flag.
- R6: A host write to address 1 stores the byte for the coprocessor and sets the data flag. A coprocessor read of address 1 returns that byte and clears the data flag.
- R7: When a set and a clear of the same flag fall in one cycle, the flag ends up set.
- R8: A host control write with bit 7 set drives cop_reset high for exactly RST_CYCLES (16) cycles, starting the cycle after the write. Another such write while it is active restarts the count.
- R9: A host control write with bit 6 set makes cop_nmi high for the single following cycle.
- R10: A host control write with bit 5 set inverts led_on. A control write with bit 5 clear leaves led_on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both buses |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 2 | Host port address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data (combinational) |
| c_wr | input | 1 | Coprocessor write strobe |
| c_rd | input | 1 | Coprocessor read strobe |
| c_addr | input | 3 | Coprocessor port address |
| c_wdata | input | 8 | Coprocessor write data |
| c_rdata | output | 8 | Coprocessor read data (combinational) |
| cop_reset | output | 1 | Stretched coprocessor reset, active high |
| cop_nmi | output | 1 | One-cycle NMI pulse to the coprocessor |
| led_on | output | 1 | Indicator LED drive, 1 means lit |

## Verification
The bench drives both buses in the same cycle so that a set and a clear of one flag collide. A design that let the clear win would drop a command posted just as the previous one was acknowledged, or lose a reply written as the host read the old one. It exercises the clear port by both read and write, which catches a decode that reacts to only one strobe kind. It also reads status repeatedly, which catches any side effect on a plain read. A mid-count retrigger of the reset stretcher and back-to-back LED toggles show an off-by-one count, a counter that does not restart, or a level output where a toggle was wanted.

// File: rtl/mb_pkg.sv
// Package: shared widths, port addresses and bit positions for the mailbox.
// Assumes byte-wide buses; the status bit positions are fixed at 0 and 7.
package mb_pkg;
    localparam int DATA_W = 8;
    localparam int HA_W   = 2;
    localparam int CA_W   = 3;

    // Host port map
    localparam logic [HA_W-1:0] H_CMD_STAT = 2'd0;
    localparam logic [HA_W-1:0] H_DATA     = 2'd1;
    localparam logic [HA_W-1:0] H_CTRL     = 2'd2;

    // Coprocessor port map
    localparam logic [CA_W-1:0] C_CMD   = 3'd0;
    localparam logic [CA_W-1:0] C_DRD   = 3'd1;
    localparam logic [CA_W-1:0] C_DWR   = 3'd2;
    localparam logic [CA_W-1:0] C_STAT  = 3'd3;
    localparam logic [CA_W-1:0] C_CLR   = 3'd4;

    // Status byte layout
    localparam int ST_CMD_BIT  = 0;
    localparam int ST_DATA_BIT = 7;

    // Control byte layout
    localparam int CT_RST_BIT = 7;
    localparam int CT_NMI_BIT = 6;
    localparam int CT_LED_BIT = 5;

    // Flag vector indices
    localparam int NFLAGS = 2;
    localparam int F_CMD  = 0;
    localparam int F_DATA = 1;
endpackage

// File: rtl/mb_flags.sv
// Module: mb_flags - a vector of independent set/clear flags.
// Each flag is set when its set input is high (set has priority over
// clear), cleared when only its clear input is high, else it holds.
// Assumes synchronous active-low reset to all zeros.
module mb_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // Set-dominant flag bit g
        always_ff @(posedge clk) begin
            if (!rst_n)          q_o[g] <= 1'b0;
            else if (set_i[g])   q_o[g] <= 1'b1;
            else if (clr_i[g])   q_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/mb_reg.sv
// Module: mb_reg - a holding register with a load enable.
// Assumes synchronous active-low reset to zero.
module mb_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Capture the byte on load, keep it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= '0;
        else if (ld_i)  q_o <= d_i;
    end
endmodule

// File: rtl/mb_ctrl.sv
// Module: mb_ctrl - coprocessor side channels driven by host control writes.
// rst_req starts a reset of RST_CYCLES cycles (a new request restarts it),
// nmi_req gives a one-cycle pulse, led_req inverts the LED drive.
// Assumes the request inputs are already qualified by the write strobe.
module mb_ctrl #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_req,
    input  logic nmi_req,
    input  logic led_req,
    output logic cop_reset,
    output logic cop_nmi,
    output logic led_on
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Reset stretcher: load on request, count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (rst_req)        cnt_q <= CW'(RST_CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign cop_reset = (cnt_q != '0);

    // One-cycle NMI pulse following a request
    always_ff @(posedge clk) begin
        if (!rst_n) cop_nmi <= 1'b0;
        else        cop_nmi <= nmi_req;
    end

    // LED drive, lit after reset, inverted on request
    always_ff @(posedge clk) begin
        if (!rst_n)       led_on <= 1'b1;
        else if (led_req) led_on <= ~led_on;
    end
endmodule

// File: rtl/host_mailbox.sv
// Module: host_mailbox - byte mailbox between a host bus and a
// coprocessor bus with command-pending and data-ready flags, plus
// host-driven reset, NMI and LED side channels.
// Assumes one shared clock, single-cycle read/write strobes, and
// combinational read data that shows state before the strobe's edge.
module host_mailbox
    import mb_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [HA_W-1:0]   h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              c_wr,
    input  logic              c_rd,
    input  logic [CA_W-1:0]   c_addr,
    input  logic [DATA_W-1:0] c_wdata,
    output logic [DATA_W-1:0] c_rdata,
    output logic              cop_reset,
    output logic              cop_nmi,
    output logic              led_on
);
    // Decoded accesses
    logic h_cmd_wr, h_dat_wr, h_dat_rd, h_ctl_wr;
    logic c_dat_rd, c_dat_wr, c_clr_hit;

    logic [NFLAGS-1:0] flag_set, flag_clr, flags;
    logic              cmd_flag, data_flag;
    logic [DATA_W-1:0] cmd_q, h2c_q, c2h_q, status;

    // Decode both bus strobes into access events
    always_comb begin
        h_cmd_wr  = h_wr && (h_addr == H_CMD_STAT);
        h_dat_wr  = h_wr && (h_addr == H_DATA);
        h_dat_rd  = h_rd && (h_addr == H_DATA);
        h_ctl_wr  = h_wr && (h_addr == H_CTRL);
        c_dat_rd  = c_rd && (c_addr == C_DRD);
        c_dat_wr  = c_wr && (c_addr == C_DWR);
        c_clr_hit = (c_rd || c_wr) && (c_addr == C_CLR);
    end

    // Route access events onto flag set/clear lines
    always_comb begin
        flag_set         = '0;
        flag_clr         = '0;
        flag_set[F_CMD]  = h_cmd_wr;
        flag_clr[F_CMD]  = c_clr_hit;
        flag_set[F_DATA] = h_dat_wr || c_dat_wr;
        flag_clr[F_DATA] = h_dat_rd || c_dat_rd;
    end

    mb_flags #(.N(NFLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .q_o   (flags)
    );

    assign cmd_flag  = flags[F_CMD];
    assign data_flag = flags[F_DATA];

    mb_reg #(.W(DATA_W)) u_cmd (
        .clk (clk), .rst_n (rst_n), .ld_i (h_cmd_wr), .d_i (h_wdata), .q_o (cmd_q)
    );

    mb_reg #(.W(DATA_W)) u_h2c (
        .clk (clk), .rst_n (rst_n), .ld_i (h_dat_wr), .d_i (h_wdata), .q_o (h2c_q)
    );

    mb_reg #(.W(DATA_W)) u_c2h (
        .clk (clk), .rst_n (rst_n), .ld_i (c_dat_wr), .d_i (c_wdata), .q_o (c2h_q)
    );

    mb_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_req   (h_ctl_wr && h_wdata[CT_RST_BIT]),
        .nmi_req   (h_ctl_wr && h_wdata[CT_NMI_BIT]),
        .led_req   (h_ctl_wr && h_wdata[CT_LED_BIT]),
        .cop_reset (cop_reset),
        .cop_nmi   (cop_nmi),
        .led_on    (led_on)
    );

    // Assemble the shared status byte
    always_comb begin
        status              = '0;
        status[ST_CMD_BIT]  = cmd_flag;
        status[ST_DATA_BIT] = data_flag;
    end

    // Host read mux
    always_comb begin
        unique case (h_addr)
            H_CMD_STAT: h_rdata = status;
            H_DATA:     h_rdata = c2h_q;
            default:    h_rdata = '0;
        endcase
    end

    // Coprocessor read mux
    always_comb begin
        unique case (c_addr)
            C_CMD:   c_rdata = cmd_q;
            C_DRD:   c_rdata = h2c_q;
            C_STAT:  c_rdata = status;
            default: c_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mb_chk.sv
// Module: mb_chk - protocol checker for host_mailbox, bound to the top.
// Assumes the port map and bit positions from mb_pkg.
module mb_chk
    import mb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              h_wr,
    input logic [HA_W-1:0]   h_addr,
    input logic [DATA_W-1:0] h_wdata,
    input logic              c_wr,
    input logic              c_rd,
    input logic [CA_W-1:0]   c_addr,
    input logic              cmd_flag,
    input logic              data_flag,
    input logic              cop_reset,
    input logic              cop_nmi,
    input logic              led_on
);
    // R3
    cmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr == H_CMD_STAT) |=> cmd_flag);

    // R4
    cmd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_rd || c_wr) && c_addr == C_CLR && !(h_wr && h_addr == H_CMD_STAT)) |=> !cmd_flag);

    // R5
    data_set_cop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_addr == C_DWR) |=> data_flag);

    // R6
    data_set_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr == H_DATA) |=> data_flag);

    // R8
    reset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cop_reset) |-> $past(h_wr && h_addr == H_CTRL && h_wdata[CT_RST_BIT]));

    // R9
    nmi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cop_nmi |-> $past(h_wr && h_addr == H_CTRL && h_wdata[CT_NMI_BIT]));

    // R10
    led_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led_on) |-> $past(h_wr && h_addr == H_CTRL && h_wdata[CT_LED_BIT]));
endmodule

bind host_mailbox mb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_wr      (h_wr),
    .h_addr    (h_addr),
    .h_wdata   (h_wdata),
    .c_wr      (c_wr),
    .c_rd      (c_rd),
    .c_addr    (c_addr),
    .cmd_flag  (cmd_flag),
    .data_flag (data_flag),
    .cop_reset (cop_reset),
    .cop_nmi   (cop_nmi),
    .led_on    (led_on)
);

// File: tb/host_mailbox_bench.sv
// Bench: behavioural reference model of the mailbox, compared every clock.
module host_mailbox_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_wr = 1'b0, h_rd = 1'b0;
    logic [1:0] h_addr = '0;
    logic [7:0] h_wdata = '0;
    logic [7:0] h_rdata;
    logic       c_wr = 1'b0, c_rd = 1'b0;
    logic [2:0] c_addr = '0;
    logic [7:0] c_wdata = '0;
    logic [7:0] c_rdata;
    logic       cop_reset, cop_nmi, led_on;

    int checks = 0;
    int errors = 0;

    // Reference model state
    int   m_cmd = 0, m_h2c = 0, m_c2h = 0;
    bit   m_cf = 0, m_df = 0, m_nmi = 0, m_led = 1;
    int   m_rcnt = 0;

    always #2 clk = ~clk;

    host_mailbox u_host_mailbox (
        .clk(clk), .rst_n(rst_n),
        .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .c_wr(c_wr), .c_rd(c_rd), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .cop_reset(cop_reset), .cop_nmi(cop_nmi), .led_on(led_on)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int status_m();
        return (m_df ? 8'h80 : 8'h00) | (m_cf ? 8'h01 : 8'h00);
    endfunction

    // One bus cycle on both sides; checks outputs before the edge, then steps the model
    task automatic step(input bit hw, input bit hr, input int ha, input int hd,
                        input bit cw, input bit cr, input int ca, input int cd,
                        input string tag);
        int exp;
        bit hcmdw, hdw, hdr, hctl, cdr, cdw, cclr;
        @(negedge clk);
        h_wr = hw; h_rd = hr; h_addr = 2'(ha); h_wdata = 8'(hd);
        c_wr = cw; c_rd = cr; c_addr = 3'(ca); c_wdata = 8'(cd);
        #1;
        check(cop_reset == (m_rcnt != 0), "R8", cop_reset, m_rcnt != 0);
        check(cop_nmi == m_nmi, "R9", cop_nmi, m_nmi);
        check(led_on == m_led, "R10", led_on, m_led);
        if (hr && ha != 2) begin
            exp = (ha == 0) ? status_m() : m_c2h;
            check(h_rdata == 8'(exp), tag != "" ? tag : (ha == 0 ? "R2" : "R5"), h_rdata, exp);
        end
        if (cr && (ca <= 1 || ca == 3)) begin
            exp = (ca == 0) ? m_cmd : (ca == 1) ? m_h2c : status_m();
            check(c_rdata == 8'(exp), tag != "" ? tag : (ca == 0 ? "R3" : ca == 1 ? "R6" : "R2"), c_rdata, exp);
        end
        @(posedge clk);
        hcmdw = hw && ha == 0; hdw = hw && ha == 1; hdr = hr && ha == 1; hctl = hw && ha == 2;
        cdr = cr && ca == 1; cdw = cw && ca == 2; cclr = (cr || cw) && ca == 4;
        if (hcmdw) begin m_cmd = hd; m_cf = 1; end
        else if (cclr) m_cf = 0;
        if (hdw) m_h2c = hd;
        if (cdw) m_c2h = cd;
        if (hdw || cdw) m_df = 1;
        else if (hdr || cdr) m_df = 0;
        if (hctl && hd[7]) m_rcnt = 16;
        else if (m_rcnt > 0) m_rcnt--;
        m_nmi = hctl && hd[6];
        if (hctl && hd[5]) m_led = !m_led;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic hwrite(input int a, input int d, input string t);
        step(1, 0, a, d, 0, 0, 0, 0, t);
    endtask
    task automatic hread(input int a, input string t);
        step(0, 1, a, 0, 0, 0, 0, 0, t);
    endtask
    task automatic cwrite(input int a, input int d, input string t);
        step(0, 0, 0, 0, 1, 0, a, d, t);
    endtask
    task automatic cread(input int a, input string t);
        step(0, 0, 0, 0, 0, 1, a, 0, t);
    endtask

    // Watchdog
    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at every port
        check(cop_reset == 0 && cop_nmi == 0 && led_on == 1, "R1", {cop_reset, cop_nmi, led_on}, 3'b001);
        hread(0, "R1"); cread(3, "R1"); cread(0, "R1"); cread(1, "R1"); hread(1, "R1");

        // R3: command post, R2: status on both sides, no side effect of status reads
        hwrite(0, 8'h5A, "R3");
        cread(3, "R2"); hread(0, "R2"); cread(0, "R3"); cread(3, "R2");
        // R4: clear by read, then by write
        cread(4, "R4"); cread(3, "R4");
        hwrite(0, 8'h33, "R3"); hread(0, "R2");
        cwrite(4, 8'hFF, "R4"); hread(0, "R4"); cread(0, "R3");

        // R5: coprocessor reply, host reads and clears
        cwrite(2, 8'hC3, "R5"); hread(0, "R5"); hread(1, "R5"); hread(0, "R5"); hread(1, "R5");
        // R6: host data, coprocessor reads and clears
        hwrite(1, 8'h7E, "R6"); cread(3, "R6"); cread(1, "R6"); cread(3, "R6");

        // R7: set and clear in one cycle
        step(1, 0, 0, 8'hA5, 0, 1, 4, 0, "R7"); cread(3, "R7"); cread(0, "R7");
        step(1, 0, 1, 8'h11, 0, 1, 1, 0, "R7"); cread(3, "R7"); cread(1, "R7");
        step(0, 1, 1, 0, 1, 0, 2, 8'h22, "R7"); hread(0, "R7"); hread(1, "R7");
        cwrite(4, 0, "R4"); hread(0, "R2");

        // R8: stretched reset, retrigger mid-count
        hwrite(2, 8'h80, "R8"); idle(8);
        hwrite(2, 8'h80, "R8"); idle(20);
        // R9: NMI pulse, back to back
        hwrite(2, 8'h40, "R9"); idle(3);
        hwrite(2, 8'h40, "R9"); hwrite(2, 8'h40, "R9"); idle(3);
        // R10: toggles, and no change without bit 5
        hwrite(2, 8'h20, "R10"); hwrite(2, 8'h20, "R10"); hwrite(2, 8'h1F, "R10");
        hwrite(2, 8'h20, "R10"); idle(2);
        hwrite(2, 8'hE0, "R8"); idle(20);

        // Mixed traffic sweep
        for (int i = 0; i < 40; i++) begin
            step(i % 3 == 0, i % 5 == 1, i % 2, (i * 37) & 8'hFF,
                 i % 4 == 2, i % 3 == 1, i % 5, (i * 91) & 8'hFF, "");
        end
        idle(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule